// File: doc/BRIEF.md
# Execution-Unit Run-Time Power Gating Controller

This block sits beside the execute stage of a simple in-order 32-bit pipeline. It decides every cycle which of four execution function units have power. The four units are the general logic unit, the shifter, the multiplier and the divider. Decode hands it a class code for the operation about to execute. The controller keeps only that unit powered and puts every other unit to sleep.

When the requested unit is asleep, the controller raises a stall request. The stall stays up until the unit has counted through its wake latency. While a unit wakes, its power-switch groups are turned on one group per cycle rather than all together. This limits the inrush current.

Software can set a hold mask so that chosen units are never gated. Out of reset every unit is powered. Gating starts only once the first operation has been decoded.

Top module: `exu_pwr_gate_ctrl`

## Requirements
- R1: `op_unit` selects the unit with code 0 = general logic unit, 1 = shifter, 2 = multiplier, 3 = divider. Bit k of `unit_sleep`, `unit_ready` and the hold mask refers to unit code k. Switch-enable bits `sw_en[k*N_GROUPS +: N_GROUPS]` belong to unit k.
- R2: From reset until the first clock edge with `op_valid` high, and through that edge, every unit shows sleep low, ready high and all switch groups enabled. Stall is low.
- R3: Once an operation has been seen, `unit_sleep[k]` after each edge is low exactly when, at that edge, the hold bit k was set or `op_valid` was high with `op_unit == k`.
- R4: A unit that was asleep shows `unit_ready` high exactly WAKE_CYCLES edges after the edge that dropped its sleep signal, provided it stays requested throughout. Ready is never high while the unit sleeps.
- R5: `stall` is high exactly when `op_valid` is high and the unit selected by `op_unit` is not ready.
- R6: A sleeping unit has all of its switch-enable bits low. On the edge that wakes it, bit 0 turns on. Each following edge adds the next higher bit until all N_GROUPS bits are on.
- R7: A write with `cfg_we` high loads `cfg_hold` into the hold mask at that edge. From the next edge on, held units stay awake whatever `op_valid` and `op_unit` do.
- R8: Back-to-back operations on a unit that is already ready produce no stall and keep that unit ready.
- R9: With gating active and an empty hold mask, at most one unit is awake after any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is presented |
| op_unit | input | 2 | Unit class code of that operation (R1 encoding) |
| cfg_we | input | 1 | Write strobe for the hold mask |
| cfg_hold | input | 4 | New hold mask, bit k keeps unit k powered |
| unit_sleep | output | 4 | Sleep request per unit, high = power cut |
| unit_ready | output | 4 | Unit has finished waking and is usable |
| sw_en | output | 4*N_GROUPS | Staggered power-switch group enables |
| stall | output | 1 | Hold the pipeline, the needed unit is not ready |

## Verification
The bench probes the first decoded operation. A design that began gating one edge early would put the other units to sleep while software still expects them powered. It switches abruptly between units, which exposes an off-by-one in the wake count: the stall would be one cycle too short or too long.

The bench also writes the hold mask while operations are flowing. A mask applied in the wrong cycle, or ignored, leaves a held unit asleep and stalls an operation that should run straight through. Finally, the bench checks the staggered enables on every wake. A design that turned on all groups at once, or forgot to clear them at sleep, differs bit by bit from the model.

// File: rtl/exu_pg_pkg.sv
package exu_pg_pkg;

    // Number of gated execution units; the class code below indexes them.
    localparam int N_UNITS = 4;
    localparam int UNIT_W  = $clog2(N_UNITS);

    typedef enum logic [UNIT_W-1:0] {
        UNIT_LOGIC = 2'd0,
        UNIT_SHIFT = 2'd1,
        UNIT_MULT  = 2'd2,
        UNIT_DIVD  = 2'd3
    } unit_e;

endpackage

// File: rtl/exu_pg_demand.sv
// Combinational demand decode: which units must hold power next edge.
module exu_pg_demand
    import exu_pg_pkg::*;
(
    input  logic               op_valid,
    input  logic [UNIT_W-1:0]  op_unit,
    input  logic [N_UNITS-1:0] hold,
    input  logic               armed,
    output logic [N_UNITS-1:0] want
);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_want
        // Before the first operation everything stays powered.
        assign want[u] = hold[u] | ~armed |
                         (op_valid & (op_unit == UNIT_W'(u)));
    end

endmodule

// File: rtl/exu_pg_unit.sv
// Per-unit wake sequencer: sleep flag, wake latency counter and
// staggered switch-group enables.
module exu_pg_unit #(
    parameter int WAKE_CYCLES = 2,
    parameter int N_GROUPS    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                want,
    output logic                sleep,
    output logic                ready,
    output logic [N_GROUPS-1:0] sw_en
);

    localparam int CW = (WAKE_CYCLES > 0) ? $clog2(WAKE_CYCLES + 1) : 1;
    localparam int GW = $clog2(N_GROUPS + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(WAKE_CYCLES);
    localparam logic [GW-1:0] GRP_FULL = GW'(N_GROUPS);

    typedef struct packed {
        logic          sleep;
        logic [CW-1:0] cnt;
        logic [GW-1:0] grp;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (want) begin
            seq_d.sleep = 1'b0;
            if (seq_q.sleep) begin
                // Waking edge: first switch group on, latency count restarts.
                seq_d.cnt = '0;
                seq_d.grp = GW'(1);
            end else begin
                if (seq_q.cnt != CNT_DONE) seq_d.cnt = seq_q.cnt + CW'(1);
                if (seq_q.grp != GRP_FULL) seq_d.grp = seq_q.grp + GW'(1);
            end
        end else begin
            seq_d.sleep = 1'b1;
            seq_d.cnt   = '0;
            seq_d.grp   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.sleep <= 1'b0;
            seq_q.cnt   <= CNT_DONE;
            seq_q.grp   <= GRP_FULL;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sleep = seq_q.sleep;
    assign ready = ~seq_q.sleep & (seq_q.cnt == CNT_DONE);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_sw
        assign sw_en[g] = (GW'(g) < seq_q.grp);
    end

endmodule

// File: rtl/exu_pwr_gate_ctrl.sv
module exu_pwr_gate_ctrl
    import exu_pg_pkg::*;
#(
    parameter int WAKE_CYCLES = 2,
    parameter int N_GROUPS    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [1:0]                    op_unit,
    input  logic                          cfg_we,
    input  logic [3:0]                    cfg_hold,
    output logic [3:0]                    unit_sleep,
    output logic [3:0]                    unit_ready,
    output logic [4*N_GROUPS-1:0]         sw_en,
    output logic                          stall
);

    localparam int SW_W = N_UNITS * N_GROUPS;

    typedef struct packed {
        logic [N_UNITS-1:0] hold;
        logic               armed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [N_UNITS-1:0] want;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we)   ctl_d.hold  = cfg_hold;
        if (op_valid) ctl_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    exu_pg_demand u_demand (
        .op_valid (op_valid),
        .op_unit  (op_unit),
        .hold     (ctl_q.hold),
        .armed    (ctl_q.armed),
        .want     (want)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        exu_pg_unit #(
            .WAKE_CYCLES (WAKE_CYCLES),
            .N_GROUPS    (N_GROUPS)
        ) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want[u]),
            .sleep (unit_sleep[u]),
            .ready (unit_ready[u]),
            .sw_en (sw_en[u*N_GROUPS +: N_GROUPS])
        );
    end

    assign stall = op_valid & ~unit_ready[op_unit];

    logic unused_w;
    assign unused_w = ^SW_W;

endmodule

// File: rtl/exu_pg_checker.sv
module exu_pg_checker #(
    parameter int N_GROUPS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [1:0]            op_unit,
    input logic                  cfg_we,
    input logic [3:0]            cfg_hold,
    input logic [3:0]            unit_sleep,
    input logic [3:0]            unit_ready,
    input logic [4*N_GROUPS-1:0] sw_en,
    input logic                  stall
);

    // Independent mirrors of the hold mask and the armed flag.
    logic [3:0] hold_m;
    logic       armed_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_m  <= '0;
            armed_m <= 1'b0;
        end else begin
            if (cfg_we)   hold_m  <= cfg_hold;
            if (op_valid) armed_m <= 1'b1;
        end
    end

    assert_stall_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && unit_ready[op_unit]) |-> !stall);

    assert_stall_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !unit_ready[op_unit]) |-> stall);

    assert_held_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_m) & unit_sleep) == 4'b0);

    assert_single_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed_m) && $past(hold_m) == 4'b0) |-> $onehot0(~unit_sleep));

    for (genvar u = 0; u < 4; u++) begin : g_unit_chk
        assert_ready_needs_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_ready[u] |-> !unit_sleep[u]);

        assert_sleep_no_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
            unit_sleep[u] |-> (sw_en[u*N_GROUPS +: N_GROUPS] == '0));

        assert_wake_one_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(unit_sleep[u]) |-> ($countones(sw_en[u*N_GROUPS +: N_GROUPS]) == 1));
    end

endmodule

bind exu_pwr_gate_ctrl exu_pg_checker #(.N_GROUPS(N_GROUPS)) u_pg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_unit    (op_unit),
    .cfg_we     (cfg_we),
    .cfg_hold   (cfg_hold),
    .unit_sleep (unit_sleep),
    .unit_ready (unit_ready),
    .sw_en      (sw_en),
    .stall      (stall)
);

// File: tb/exu_pwr_gate_ctrl_test.sv
`timescale 1ns/100ps
module exu_pwr_gate_ctrl_test;

    localparam int W  = 2;
    localparam int G  = 4;
    localparam int NU = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [1:0]      op_unit = '0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_hold = '0;
    logic [3:0]      unit_sleep, unit_ready;
    logic [NU*G-1:0] sw_en;
    logic            stall;

    always #2.5 clk = ~clk;

    exu_pwr_gate_ctrl #(.WAKE_CYCLES(W), .N_GROUPS(G)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_unit(op_unit),
        .cfg_we(cfg_we), .cfg_hold(cfg_hold), .unit_sleep(unit_sleep),
        .unit_ready(unit_ready), .sw_en(sw_en), .stall(stall)
    );

    // Behavioural reference: per unit a sleep bit and an age in cycles since wake.
    bit         m_sleep [NU];
    int         m_age   [NU];
    bit         m_armed;
    bit [3:0]   m_hold;
    bit         m_single;
    int         checks = 0;
    int         errors = 0;

    function automatic bit m_ready(int k);
        return !m_sleep[k] && m_age[k] >= W;
    endfunction

    function automatic int m_mask(int k);
        int n;
        if (m_sleep[k]) return 0;
        n = (m_age[k] + 1 < G) ? m_age[k] + 1 : G;
        return (1 << n) - 1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NU; k++) begin
            m_sleep[k] = 1'b0;
            m_age[k]   = 1000;
        end
        m_armed  = 1'b0;
        m_hold   = '0;
        m_single = 1'b0;
    endtask

    task automatic step(bit v, int u, bit we, bit [3:0] h, string ph);
        bit want;
        @(negedge clk);
        op_valid = v;
        op_unit  = 2'(u);
        cfg_we   = we;
        cfg_hold = h;
        #1;
        for (int k = 0; k < NU; k++) begin
            chk({ph, " R3"}, $sformatf("sleep[%0d]", k), int'(unit_sleep[k]), int'(m_sleep[k]));
            chk({ph, " R4"}, $sformatf("ready[%0d]", k), int'(unit_ready[k]), int'(m_ready(k)));
            chk({ph, " R6"}, $sformatf("sw_en[%0d]", k), int'(sw_en[k*G +: G]), m_mask(k));
        end
        chk({ph, " R5"}, "stall", int'(stall), int'(v && !m_ready(u)));
        if (m_single)
            chk({ph, " R9"}, "awake units<=1", int'($countones(~unit_sleep) <= 1), 1);
        @(posedge clk);
        m_single = m_armed && (m_hold == 4'b0);
        for (int k = 0; k < NU; k++) begin
            want = m_hold[k] || !m_armed || (v && u == k);
            if (want) begin
                if (m_sleep[k]) begin
                    m_sleep[k] = 1'b0;
                    m_age[k]   = 0;
                end else if (m_age[k] < 1000) begin
                    m_age[k]++;
                end
            end else begin
                m_sleep[k] = 1'b1;
                m_age[k]   = 0;
            end
        end
        if (we) m_hold = h;
        if (v)  m_armed = 1'b1;
    endtask

    // Present an operation until its unit is ready, then issue it once.
    task automatic run_op(int u, string ph);
        for (int n = 0; n < 12; n++) begin
            bit rdy;
            rdy = m_ready(u);
            step(1'b1, u, 1'b0, 4'b0, ph);
            if (rdy) break;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: everything powered before any operation
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0, 4'b0, "R2");
        chk("R2", "all ready", int'(unit_ready), 15);

        // First op on the multiplier (code 2): no stall, gating then begins; R8 back-to-back
        for (int i = 0; i < 5; i++) step(1'b1, 2, 1'b0, 4'b0, "R8");

        // Switch to divider: wake latency, staggered groups (R4, R6)
        run_op(3, "R4");
        for (int i = 0; i < 5; i++) step(1'b1, 3, 1'b0, 4'b0, "R6");

        // Idle: all units sleep
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0, 4'b0, "R9");
        chk("R9", "all asleep", int'(unit_sleep), 15);

        // R1: each class code wakes its own unit
        for (int u = 0; u < NU; u++) begin
            run_op(u, "R1");
            step(1'b1, u, 1'b0, 4'b0, "R1");
            chk("R1", $sformatf("code %0d awake", u), int'(unit_sleep), 15 & ~(1 << u));
        end

        // R7: hold the shifter, then hammer other units
        step(1'b0, 0, 1'b1, 4'b0010, "R7");
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 4'b0, "R7");
        run_op(2, "R7");
        run_op(3, "R7");
        chk("R7", "shifter held awake", int'(unit_sleep[1]), 0);
        step(1'b1, 1, 1'b0, 4'b0, "R7");
        chk("R7", "held unit no stall", int'(stall), 0);

        // R7: hold all, then release and return to single-unit gating
        step(1'b0, 0, 1'b1, 4'b1111, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b0, 4'b0, "R7");
        step(1'b1, 0, 1'b1, 4'b0000, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b0, 4'b0, "R9");

        // Rapid alternation between two sleeping units (R5)
        for (int i = 0; i < 3; i++) begin
            run_op(2, "R5");
            run_op(3, "R5");
        end
        for (int i = 0; i < 2; i++) step(1'b0, 0, 1'b0, 4'b0, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule